// File: doc/BRIEF.md
# Floating-Point Register Upper-Half Mover

This unit copies the upper 32-bit half of a floating-point register into an integer result, or fills that half from an integer operand. It contains a file of 32 floating-point registers, each 64 bits wide. A mode input sets how the file is seen. In wide mode there are 32 independent 64-bit registers. In paired mode, 32-bit registers sit in pairs: an even/odd pair forms one 64-bit value, and the odd register of the pair holds the upper half.

A command is one 32-bit instruction word plus a 64-bit integer operand. Commands arrive on a valid/ready channel. Each accepted command produces exactly one result beat on a second valid/ready channel. A result beat carries a 64-bit value, a warning flag and a coprocessor-unusable flag.

The result side holds one beat. `cmd_ready` is high when that slot is empty, or when the consumer is taking the current beat in the same cycle. While `res_valid` is high and `res_ready` is low, the beat stays unchanged and no new command is accepted. A command that writes updates the file at the clock edge that accepts it. A command accepted at any later edge sees the new contents.

Top module: `fhx_xfer`

## Requirements
- R1: A command is recognised only when all of these hold: bits 31:26 are 010001, bits 10:0 are zero, and bits 25:21 are 00011 (read-high) or 00111 (write-high). The register index fs is taken from bits 15:11. Any other word still returns one result beat, but that beat has value zero and both flags low, and the command changes no register.
- R2: When `fpu_usable` is low, a recognised command returns value zero with `res_unusable` high and `res_warn` low, and it writes no register. The usability check comes before any register access.
- R3: Read-high in wide mode (`fpr_wide`=1) returns bits 63:32 of register fs, sign-extended from bit 31 to 64 bits.
- R4: Read-high in paired mode with an even fs returns bits 31:0 of register fs+1, sign-extended to 64 bits.
- R5: Read-high in paired mode with an odd fs returns 0x000000000BADF00D with `res_warn` high.
- R6: Write-high in wide mode sets bits 63:32 of register fs to bits 31:0 of the operand and keeps bits 31:0 of fs.
- R7: Write-high in paired mode with an even fs sets bits 31:0 of register fs+1 to bits 31:0 of the operand and keeps bits 63:32 of fs+1. At most one half of one register changes per command.
- R8: Write-high in paired mode with an odd fs sets bits 31:0 of register fs to 0xDEADC0DE, returns `res_warn` high, and keeps bits 63:32 of fs. A write-high that warns returns value zero.
- R9: A write made by one command is visible to the next command, even when that command is accepted in the very next cycle.
- R10: `cmd_ready` equals `!res_valid || res_ready`. A result beat stays stable while `res_valid` is high and `res_ready` is low.
- R11: After reset, `res_valid` is low and every register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_insn | input | 32 | Instruction word |
| cmd_gpr | input | 64 | Integer operand; only bits 31:0 are used |
| fpu_usable | input | 1 | Floating-point unit enabled |
| fpr_wide | input | 1 | 1 = 64-bit register mode, 0 = paired 32-bit mode |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the beat |
| res_data | output | 64 | Sign-extended integer result |
| res_warn | output | 1 | Odd register used in paired mode |
| res_unusable | output | 1 | Command refused because the unit is disabled |

## Verification
The assertions make no assumption about `res_ready`: the consumer may stall for any number of cycles, and the hold and stall properties must then still hold. They do assume that the mode and usability bits are sampled only with an accepted command. The stimulus changes those bits only in the same cycle that it drives a new command. It keeps `cmd_valid` low while it holds the result channel stalled, so no command is lost or duplicated.

// File: rtl/fhx_pkg.sv
package fhx_pkg;
  localparam logic [5:0]  OPC_FPU  = 6'b010001;
  localparam logic [4:0]  SUB_RDHI = 5'b00011;
  localparam logic [4:0]  SUB_WRHI = 5'b00111;
  localparam logic [31:0] MARK_RD  = 32'h0BADF00D;
  localparam logic [31:0] MARK_WR  = 32'hDEADC0DE;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RDHI = 2'd1,
    OP_WRHI = 2'd2
  } op_e;
endpackage

// File: rtl/fhx_decode.sv
module fhx_decode
  import fhx_pkg::*;
#(
  parameter int unsigned FS_W = 5
) (
  input  logic [31:0]     insn,
  output op_e             op,
  output logic [FS_W-1:0] fs
);
  logic base_ok;

  assign base_ok = (insn[31:26] == OPC_FPU) && (insn[10:0] == 11'd0);
  assign fs      = insn[11 +: FS_W];

  always_comb begin
    op = OP_NONE;
    if (base_ok) begin
      if (insn[25:21] == SUB_RDHI)      op = OP_RDHI;
      else if (insn[25:21] == SUB_WRHI) op = OP_WRHI;
    end
  end
endmodule

// File: rtl/fhx_regfile.sv
module fhx_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned HALF = 32,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned DW  = 2 * HALF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [AW-1:0]   wr_addr,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HALF-1:0] wr_data
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (wr_addr == AW'(g)) begin
        if (wr_lo) mem[g][HALF-1:0]  <= wr_data;
        if (wr_hi) mem[g][DW-1:HALF] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fhx_route.sv
module fhx_route
  import fhx_pkg::*;
#(
  parameter int unsigned FS_W = 5,
  parameter int unsigned HALF = 32,
  localparam int unsigned DW  = 2 * HALF
) (
  input  op_e             op,
  input  logic [FS_W-1:0] fs,
  input  logic            wide,
  input  logic            usable,
  input  logic            fire,
  input  logic [HALF-1:0] gpr_lo,
  input  logic [DW-1:0]   rd_data,
  output logic [FS_W-1:0] rd_addr,
  output logic [FS_W-1:0] wr_addr,
  output logic            wr_lo,
  output logic            wr_hi,
  output logic [HALF-1:0] wr_data,
  output logic [DW-1:0]   nxt_data,
  output logic            nxt_warn,
  output logic            nxt_unusable
);
  logic [FS_W-1:0] partner;
  logic            lo_req, hi_req;

  assign partner = fs | FS_W'(1);

  function automatic logic [DW-1:0] sext(input logic [HALF-1:0] v);
    return {{HALF{v[HALF-1]}}, v};
  endfunction

  always_comb begin
    rd_addr      = fs;
    wr_addr      = fs;
    lo_req       = 1'b0;
    hi_req       = 1'b0;
    wr_data      = gpr_lo;
    nxt_data     = '0;
    nxt_warn     = 1'b0;
    nxt_unusable = 1'b0;
    if (op != OP_NONE && !usable) begin
      nxt_unusable = 1'b1;
    end else if (op == OP_RDHI) begin
      if (wide) begin
        nxt_data = sext(rd_data[DW-1:HALF]);
      end else if (!fs[0]) begin
        rd_addr  = partner;
        nxt_data = sext(rd_data[HALF-1:0]);
      end else begin
        nxt_data = sext(HALF'(MARK_RD));
        nxt_warn = 1'b1;
      end
    end else if (op == OP_WRHI) begin
      if (wide) begin
        hi_req = 1'b1;
      end else if (!fs[0]) begin
        wr_addr = partner;
        lo_req  = 1'b1;
      end else begin
        lo_req   = 1'b1;
        wr_data  = HALF'(MARK_WR);
        nxt_warn = 1'b1;
      end
    end
  end

  assign wr_lo = lo_req && fire;
  assign wr_hi = hi_req && fire;
endmodule

// File: rtl/fhx_xfer.sv
module fhx_xfer
  import fhx_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned HALF = 32,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned DW  = 2 * HALF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [31:0]   cmd_insn,
  input  logic [DW-1:0] cmd_gpr,
  input  logic          fpu_usable,
  input  logic          fpr_wide,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          res_warn,
  output logic          res_unusable
);
  op_e           op;
  logic [AW-1:0] fs, rd_addr, wr_addr;
  logic          wr_lo, wr_hi, fire;
  logic [HALF-1:0] wr_data;
  logic [DW-1:0] rd_data, nxt_data;
  logic          nxt_warn, nxt_unusable;

  assign cmd_ready = !res_valid || res_ready;
  assign fire      = cmd_valid && cmd_ready;

  fhx_decode #(.FS_W(AW)) u_dec (
    .insn (cmd_insn),
    .op   (op),
    .fs   (fs)
  );

  fhx_route #(.FS_W(AW), .HALF(HALF)) u_route (
    .op           (op),
    .fs           (fs),
    .wide         (fpr_wide),
    .usable       (fpu_usable),
    .fire         (fire),
    .gpr_lo       (cmd_gpr[HALF-1:0]),
    .rd_data      (rd_data),
    .rd_addr      (rd_addr),
    .wr_addr      (wr_addr),
    .wr_lo        (wr_lo),
    .wr_hi        (wr_hi),
    .wr_data      (wr_data),
    .nxt_data     (nxt_data),
    .nxt_warn     (nxt_warn),
    .nxt_unusable (nxt_unusable)
  );

  fhx_regfile #(.NREG(NREG), .HALF(HALF)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_addr (wr_addr),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_warn     <= 1'b0;
      res_unusable <= 1'b0;
    end else if (fire) begin
      res_valid    <= 1'b1;
      res_data     <= nxt_data;
      res_warn     <= nxt_warn;
      res_unusable <= nxt_unusable;
    end else if (res_ready) begin
      res_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/fhx_xfer_chk.sv
module fhx_xfer_chk #(
  parameter int unsigned DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          fpu_usable,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          res_warn,
  input logic          res_unusable,
  input logic          wr_lo,
  input logic          wr_hi
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_warn) && $stable(res_unusable));

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !cmd_ready);

  // R2
  unusable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_unusable |-> res_data == '0 && !res_warn);

  // R2
  unusable_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !fpu_usable |-> !wr_lo && !wr_hi);

  // R7
  one_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_lo, wr_hi}) <= 1);

  // R5
  warn_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_warn && res_data != '0 |-> res_data == DW'(64'h0BADF00D));
endmodule

bind fhx_xfer fhx_xfer_chk #(.DW(DW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .fpu_usable   (fpu_usable),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_data     (res_data),
  .res_warn     (res_warn),
  .res_unusable (res_unusable),
  .wr_lo        (wr_lo),
  .wr_hi        (wr_hi)
);

// File: tb/test_fhx_xfer.sv
module test_fhx_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_insn = '0;
  logic [63:0] cmd_gpr = '0;
  logic        fpu_usable = 1'b1;
  logic        fpr_wide = 1'b1;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;
  logic        res_warn;
  logic        res_unusable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fhx_xfer i_fhx_xfer (.*);

  function automatic logic [31:0] rd_w(input int fs);
    return {6'b010001, 5'b00011, 5'd2, 5'(fs), 11'd0};
  endfunction
  function automatic logic [31:0] wr_w(input int fs);
    return {6'b010001, 5'b00111, 5'd2, 5'(fs), 11'd0};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one command, return the beat seen one cycle later
  task automatic send(input logic [31:0] insn, input logic [63:0] gpr, input logic use_f,
                      input logic wide, output logic [63:0] d, output logic w, output logic u);
    @(negedge clk);
    cmd_insn = insn; cmd_gpr = gpr; fpu_usable = use_f; fpr_wide = wide; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    d = res_valid ? res_data : 64'hxxxx_xxxx_xxxx_xxxx;
    w = res_warn;
    u = res_unusable;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic w, u;
    chk("R11 res_valid after reset", {63'd0, res_valid}, 64'd0);
    chk("R10 cmd_ready idle", {63'd0, cmd_ready}, 64'd1);
    send(rd_w(5), 0, 1, 1, d, w, u);
    chk("R11 reg5 zero", d, 64'd0);
  endtask

  task automatic t_wide();
    logic [63:0] d; logic w, u;
    send(wr_w(3), 64'h1111_2222_89AB_CDEF, 1, 1, d, w, u);
    chk("R6 wide write flags", {62'd0, w, u}, 64'd0);
    send(rd_w(3), 0, 1, 1, d, w, u);
    chk("R3 R9 wide read sign-ext", d, 64'hFFFF_FFFF_89AB_CDEF);
    send(rd_w(2), 0, 1, 0, d, w, u);
    chk("R6 low half of reg3 kept", d, 64'd0);
    send(wr_w(31), 64'h0000_0000_1234_0000, 1, 1, d, w, u);
    send(rd_w(31), 0, 1, 1, d, w, u);
    chk("R3 wide read reg31 positive", d, 64'h0000_0000_1234_0000);
  endtask

  task automatic t_pair_even();
    logic [63:0] d; logic w, u;
    send(wr_w(5), 64'hCAFE_0001, 1, 1, d, w, u);
    send(wr_w(4), 64'h9999_8888_1234_5678, 1, 0, d, w, u);
    chk("R7 paired even write warn", {63'd0, w}, 64'd0);
    send(rd_w(4), 0, 1, 0, d, w, u);
    chk("R4 paired even read", d, 64'h0000_0000_1234_5678);
    send(rd_w(5), 0, 1, 1, d, w, u);
    chk("R7 upper of reg5 kept", d, 64'hFFFF_FFFF_CAFE_0001);
  endtask

  task automatic t_pair_odd();
    logic [63:0] d; logic w, u;
    send(wr_w(7), 64'h55, 1, 0, d, w, u);
    chk("R8 odd write warn", {63'd0, w}, 64'd1);
    chk("R8 odd write data", d, 64'd0);
    send(rd_w(6), 0, 1, 0, d, w, u);
    chk("R8 marker stored in reg7", d, 64'hFFFF_FFFF_DEAD_C0DE);
    send(rd_w(9), 0, 1, 0, d, w, u);
    chk("R5 odd read marker", d, 64'h0000_0000_0BAD_F00D);
    chk("R5 odd read warn", {63'd0, w}, 64'd1);
  endtask

  task automatic t_unusable();
    logic [63:0] d; logic w, u;
    send(wr_w(3), 64'h7777_7777, 0, 1, d, w, u);
    chk("R2 unusable flag", {62'd0, w, u}, 64'd1);
    chk("R2 unusable data", d, 64'd0);
    send(rd_w(3), 0, 0, 1, d, w, u);
    chk("R2 unusable read data", d, 64'd0);
    send(rd_w(3), 0, 1, 1, d, w, u);
    chk("R2 reg3 unchanged", d, 64'hFFFF_FFFF_89AB_CDEF);
  endtask

  task automatic t_unknown();
    logic [63:0] d; logic w, u;
    send(wr_w(3) | 32'h1, 64'h4444_4444, 1, 1, d, w, u);
    chk("R1 nonzero tail beat", {d[61:0], w, u}, 64'd0);
    send({6'b010001, 5'b00100, 5'd2, 5'd3, 11'd0}, 64'h4444_4444, 1, 1, d, w, u);
    chk("R1 other subop beat", {d[61:0], w, u}, 64'd0);
    send({6'b010011, 5'b00111, 5'd2, 5'd3, 11'd0}, 64'h4444_4444, 1, 1, d, w, u);
    send(rd_w(3), 0, 1, 1, d, w, u);
    chk("R1 reg3 unchanged", d, 64'hFFFF_FFFF_89AB_CDEF);
  endtask

  task automatic t_backpressure();
    logic [63:0] held;
    @(negedge clk);
    res_ready = 1'b0;
    cmd_insn = rd_w(4); fpu_usable = 1'b1; fpr_wide = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    held = res_data;
    chk("R10 stalled cmd_ready", {63'd0, cmd_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R10 held valid", {63'd0, res_valid}, 64'd1);
    chk("R10 held data", res_data, held);
    chk("R10 held value", held, 64'h0000_0000_1234_5678);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", {63'd0, res_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide();
    t_pair_even();
    t_pair_odd();
    t_unusable();
    t_unknown();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule